// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small accumulator-style processor core. Each cycle it takes a working-register operand, a second operand from a file register or an instruction literal, the current carry and digit-carry flags, and an operation code. It returns an 8-bit result together with a next value and a write enable for each of five status flags: carry, digit carry, zero, overflow and negative.

Each operation writes only its own fixed subset of the flags. The surrounding core applies the enables to its status register and routes the result to its chosen destination. Subtraction reports carry as "no borrow", so a chain of subtract-with-borrow operations feeds the carry flag straight back in. A decimal-adjust operation turns the sum of two packed BCD bytes back into packed BCD.

The result and both flag vectors are registered. A synchronous active-high reset clears them.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge clears `res_o`, `flag_nxt_o` and `flag_we_o` to zero.
- R2: Every output is registered: the values for an operation applied before a rising edge appear after that edge and hold for one cycle. Flag vector bit order is 4=N, 3=OV, 2=Z, 1=DC, 0=C. A flag whose enable is low reports next value 0. Whenever Z is written it is 1 exactly when the result is 0x00, and whenever N is written it equals result bit 7.
- R3: Code 0 gives W+f and code 1 gives W+f+C_in. Both write all five flags, with C the carry out of bit 7, DC the carry out of bit 3 and OV the signed two's-complement overflow.
- R4: Code 2 gives f−W, code 3 gives f−W−(1−C_in) and code 4 gives W−f−(1−C_in). All write all five flags, with C=1 meaning no borrow out of bit 7 and DC=1 meaning no borrow out of bit 3.
- R5: Code 5 gives f+1, code 6 gives f−1 (C and DC reported as no-borrow) and code 7 gives the two's complement of f (~f+1, reported as 0−f). All write all five flags.
- R6: Codes 8, 9 and 10 give W AND f, W OR f and W XOR f. Code 11 gives ~f and code 12 passes f through. All write only N and Z.
- R7: Code 13 rotates f left through carry (bit 7 to C, C_in to bit 0). Code 14 rotates right through carry (bit 0 to C, C_in to bit 7). Both write only N, C and Z.
- R8: Code 15 rotates f left without carry (bit 7 into bit 0). Code 16 rotates right (bit 0 into bit 7). Both write only N and Z.
- R9: Code 17 exchanges the two nibbles of f and writes no flag.
- R10: Code 18 gives 0x00 and writes only Z, as 1. Code 19 gives 0xFF and writes no flag.
- R11: Code 20 decimal-adjusts W. It adds 0x06 when W's low nibble exceeds 9 or DC_in is set. It then adds 0x60 when the high nibble of that intermediate exceeds 9 or C_in is set. Only C is written, as C_in OR any carry out of either addition, so C is never cleared by this operation.
- R12: Codes 21 to 31 pass f through and write no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File or literal operand |
| c_i | input | 1 | Current carry flag |
| dc_i | input | 1 | Current digit-carry flag |
| res_o | output | 8 | Registered result |
| flag_nxt_o | output | 5 | Next flag values {N,OV,Z,DC,C}, zero where not written |
| flag_we_o | output | 5 | Flag write enables {N,OV,Z,DC,C} |

## Verification
Every output of this block is due exactly one rising edge after its operands and operation code are applied. The result, the flag values and the enables all come from that one edge, with nothing further behind it. The bench changes inputs on the falling edge and reads all three outputs on the next falling edge, so each reading sits half a cycle after the edge that produced it. A directed test also reads the result just after the inputs change and before the next rising edge, to show that it has not yet moved. The reset test asserts reset over a non-zero output and reads zeros one falling edge later.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW   = 5;
  localparam int FLAGS = 5;

  // flag vector positions
  localparam int FC  = 0;
  localparam int FDC = 1;
  localparam int FZ  = 2;
  localparam int FOV = 3;
  localparam int FN  = 4;

  localparam logic [FLAGS-1:0] WE_ALL  = 5'b11111;
  localparam logic [FLAGS-1:0] WE_NZ   = 5'b10100;
  localparam logic [FLAGS-1:0] WE_NZC  = 5'b10101;
  localparam logic [FLAGS-1:0] WE_Z    = 5'b00100;
  localparam logic [FLAGS-1:0] WE_C    = 5'b00001;
  localparam logic [FLAGS-1:0] WE_NONE = 5'b00000;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBB  = 5'd3,
    OP_RSUBB = 5'd4,
    OP_INC   = 5'd5,
    OP_DEC   = 5'd6,
    OP_NEG   = 5'd7,
    OP_AND   = 5'd8,
    OP_OR    = 5'd9,
    OP_XOR   = 5'd10,
    OP_COMF  = 5'd11,
    OP_MOV   = 5'd12,
    OP_RLC   = 5'd13,
    OP_RRC   = 5'd14,
    OP_RL    = 5'd15,
    OP_RR    = 5'd16,
    OP_SWAP  = 5'd17,
    OP_CLR   = 5'd18,
    OP_SET   = 5'd19,
    OP_DADJ  = 5'd20
  } op_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  w,
  input  logic [DW-1:0]  f,
  input  logic           c_in,
  output logic [DW-1:0]  sum,
  output logic           co,
  output logic           dco,
  output logic           ov
);
  localparam int NIB = DW / 2;

  logic [DW-1:0] a;
  logic [DW-1:0] b;
  logic          ci;
  logic [DW:0]   full;

  // every arithmetic form maps onto a + b + ci; subtraction uses ~subtrahend
  always_comb begin
    a  = f;
    b  = '0;
    ci = 1'b0;
    case (op)
      OP_ADD:   begin a = w;  b = f;  ci = 1'b0; end
      OP_ADDC:  begin a = w;  b = f;  ci = c_in; end
      OP_SUB:   begin a = f;  b = ~w; ci = 1'b1; end
      OP_SUBB:  begin a = f;  b = ~w; ci = c_in; end
      OP_RSUBB: begin a = w;  b = ~f; ci = c_in; end
      OP_INC:   begin a = f;  b = '0; ci = 1'b1; end
      OP_DEC:   begin a = f;  b = '1; ci = 1'b0; end
      OP_NEG:   begin a = '0; b = ~f; ci = 1'b1; end
      default:  begin a = f;  b = '0; ci = 1'b0; end
    endcase
  end

  assign full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
  assign sum  = full[DW-1:0];
  assign co   = full[DW];
  // carry into bit NIB recovered from the sum bit
  assign dco  = a[NIB] ^ b[NIB] ^ full[NIB];
  assign ov   = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  w,
  input  logic [DW-1:0]  f,
  input  logic           c_in,
  output logic [DW-1:0]  res,
  output logic           c_out
);
  localparam int NIB = DW / 2;

  always_comb begin
    res   = f;
    c_out = 1'b0;
    case (op)
      OP_AND:  res = w & f;
      OP_OR:   res = w | f;
      OP_XOR:  res = w ^ f;
      OP_COMF: res = ~f;
      OP_MOV:  res = f;
      OP_RLC:  begin res = {f[DW-2:0], c_in}; c_out = f[DW-1]; end
      OP_RRC:  begin res = {c_in, f[DW-1:1]}; c_out = f[0];    end
      OP_RL:   res = {f[DW-2:0], f[DW-1]};
      OP_RR:   res = {f[0], f[DW-1:1]};
      OP_SWAP: res = {f[NIB-1:0], f[DW-1:NIB]};
      OP_CLR:  res = '0;
      OP_SET:  res = '1;
      default: res = f;
    endcase
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] w,
  input  logic          c_in,
  input  logic          dc_in,
  output logic [DW-1:0] res,
  output logic          c_out
);
  localparam int           NIB    = DW / 2;
  localparam logic [NIB-1:0] NINE = NIB'(9);
  localparam logic [DW:0]  LO_ADJ = (DW+1)'(6);
  localparam logic [DW:0]  HI_ADJ = LO_ADJ << NIB;

  logic        lo_fix;
  logic        hi_fix;
  logic [DW:0] stage1;
  logic [DW:0] stage2;

  assign lo_fix = (w[NIB-1:0] > NINE) || dc_in;
  assign stage1 = {1'b0, w} + (lo_fix ? LO_ADJ : '0);
  // upper test looks at the nibble after the lower correction
  assign hi_fix = (stage1[DW-1:NIB] > NINE) || c_in;
  assign stage2 = {1'b0, stage1[DW-1:0]} + (hi_fix ? HI_ADJ : '0);
  assign res    = stage2[DW-1:0];
  assign c_out  = c_in | stage1[DW] | stage2[DW];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPW-1:0]   op_i,
  input  logic [DW-1:0]    w_i,
  input  logic [DW-1:0]    f_i,
  input  logic             c_i,
  input  logic             dc_i,
  output logic [DW-1:0]    res_o,
  output logic [FLAGS-1:0] flag_nxt_o,
  output logic [FLAGS-1:0] flag_we_o
);
  logic [DW-1:0]    sum;
  logic             add_co;
  logic             add_dco;
  logic             add_ov;
  logic [DW-1:0]    bit_res;
  logic             rot_c;
  logic [DW-1:0]    da_res;
  logic             da_c;
  logic [DW-1:0]    res_d;
  logic [FLAGS-1:0] we_d;
  logic [FLAGS-1:0] raw_d;

  alu8_addsub #(.DW(DW)) u_addsub (
    .op(op_i), .w(w_i), .f(f_i), .c_in(c_i),
    .sum(sum), .co(add_co), .dco(add_dco), .ov(add_ov)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op(op_i), .w(w_i), .f(f_i), .c_in(c_i),
    .res(bit_res), .c_out(rot_c)
  );

  alu8_decadj #(.DW(DW)) u_decadj (
    .w(w_i), .c_in(c_i), .dc_in(dc_i),
    .res(da_res), .c_out(da_c)
  );

  always_comb begin
    res_d = bit_res;
    we_d  = WE_NONE;
    raw_d = '0;
    case (op_i)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUBB, OP_INC, OP_DEC, OP_NEG: begin
        res_d      = sum;
        we_d       = WE_ALL;
        raw_d[FC]  = add_co;
        raw_d[FDC] = add_dco;
        raw_d[FOV] = add_ov;
      end
      OP_AND, OP_OR, OP_XOR, OP_COMF, OP_MOV, OP_RL, OP_RR: begin
        we_d = WE_NZ;
      end
      OP_RLC, OP_RRC: begin
        we_d      = WE_NZC;
        raw_d[FC] = rot_c;
      end
      OP_CLR:  we_d = WE_Z;
      OP_SWAP, OP_SET: we_d = WE_NONE;
      OP_DADJ: begin
        res_d     = da_res;
        we_d      = WE_C;
        raw_d[FC] = da_c;
      end
      default: begin
        res_d = f_i;
        we_d  = WE_NONE;
      end
    endcase
    raw_d[FZ] = (res_d == '0);
    raw_d[FN] = res_d[DW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o      <= '0;
      flag_nxt_o <= '0;
      flag_we_o  <= '0;
    end else begin
      res_o      <= res_d;
      flag_nxt_o <= raw_d & we_d;
      flag_we_o  <= we_d;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [OPW-1:0]   op_i,
  input logic [DW-1:0]    w_i,
  input logic [DW-1:0]    f_i,
  input logic             c_i,
  input logic             dc_i,
  input logic [DW-1:0]    res_o,
  input logic [FLAGS-1:0] flag_nxt_o,
  input logic [FLAGS-1:0] flag_we_o
);
  localparam int NIB = DW / 2;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_o == '0 && flag_nxt_o == '0 && flag_we_o == '0));

  p_pass_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_MOV) |-> res_o == $past(f_i));

  p_arith_all_flags_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) <= OPW'(OP_NEG)) |-> flag_we_o == WE_ALL);

  p_logic_nz_only_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= OPW'(OP_AND) && $past(op_i) <= OPW'(OP_MOV))
    |-> flag_we_o == WE_NZ);

  p_rot_left_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_RL) |-> (res_o[0] == $past(f_i[DW-1]) && flag_we_o == WE_NZ));

  p_swap_nibbles_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SWAP)
    |-> (res_o == {$past(f_i[NIB-1:0]), $past(f_i[DW-1:NIB])} && flag_we_o == WE_NONE));

  p_clear_sets_z_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_CLR) |-> (res_o == '0 && flag_nxt_o[FZ] && flag_we_o == WE_Z));

  p_dadj_carry_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_DADJ && $past(c_i)) |-> (flag_nxt_o[FC] && flag_we_o == WE_C));
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .w_i(w_i), .f_i(f_i), .c_i(c_i), .dc_i(dc_i),
  .res_o(res_o), .flag_nxt_o(flag_nxt_o), .flag_we_o(flag_we_o)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] w_i = '0;
  logic [7:0] f_i = '0;
  logic       c_i = 1'b0;
  logic       dc_i = 1'b0;
  logic [7:0] res_o;
  logic [4:0] flag_nxt_o;
  logic [4:0] flag_we_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  alu8_core #(.DW(8)) i_alu8_core (
    .clk(clk), .rst(rst), .op_i(op_i), .w_i(w_i), .f_i(f_i), .c_i(c_i), .dc_i(dc_i),
    .res_o(res_o), .flag_nxt_o(flag_nxt_o), .flag_we_o(flag_we_o)
  );

  // {op, w, f, c_in, dc_in, exp_res, exp_we, exp_nxt}; flag order {N,OV,Z,DC,C}
  localparam int NV = 34;
  localparam logic [40:0] VEC [NV] = '{
    {5'd0,  8'h3C, 8'h44, 1'b0, 1'b0, 8'h80, 5'b11111, 5'b11010},
    {5'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 5'b11111, 5'b00111},
    {5'd1,  8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 5'b11111, 5'b00000},
    {5'd2,  8'h05, 8'h05, 1'b0, 1'b0, 8'h00, 5'b11111, 5'b00111},
    {5'd2,  8'h05, 8'h03, 1'b0, 1'b0, 8'hFE, 5'b11111, 5'b10000},
    {5'd2,  8'h01, 8'h80, 1'b0, 1'b0, 8'h7F, 5'b11111, 5'b01001},
    {5'd3,  8'h01, 8'h10, 1'b0, 1'b0, 8'h0E, 5'b11111, 5'b00001},
    {5'd4,  8'h20, 8'h20, 1'b1, 1'b0, 8'h00, 5'b11111, 5'b00111},
    {5'd4,  8'h20, 8'h20, 1'b0, 1'b0, 8'hFF, 5'b11111, 5'b10000},
    {5'd5,  8'h00, 8'h7F, 1'b0, 1'b0, 8'h80, 5'b11111, 5'b11010},
    {5'd5,  8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 5'b11111, 5'b00111},
    {5'd6,  8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 5'b11111, 5'b10000},
    {5'd6,  8'h00, 8'h80, 1'b0, 1'b0, 8'h7F, 5'b11111, 5'b01001},
    {5'd7,  8'h00, 8'h01, 1'b0, 1'b0, 8'hFF, 5'b11111, 5'b10000},
    {5'd7,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 5'b11111, 5'b00111},
    {5'd7,  8'h00, 8'h80, 1'b0, 1'b0, 8'h80, 5'b11111, 5'b11010},
    {5'd8,  8'hF0, 8'h0F, 1'b1, 1'b1, 8'h00, 5'b10100, 5'b00100},
    {5'd9,  8'h80, 8'h01, 1'b1, 1'b0, 8'h81, 5'b10100, 5'b10000},
    {5'd10, 8'hAA, 8'hAA, 1'b0, 1'b0, 8'h00, 5'b10100, 5'b00100},
    {5'd11, 8'h00, 8'h5A, 1'b1, 1'b1, 8'hA5, 5'b10100, 5'b10000},
    {5'd12, 8'h77, 8'h00, 1'b1, 1'b0, 8'h00, 5'b10100, 5'b00100},
    {5'd13, 8'h00, 8'h81, 1'b0, 1'b0, 8'h02, 5'b10101, 5'b00001},
    {5'd13, 8'h00, 8'h00, 1'b1, 1'b0, 8'h01, 5'b10101, 5'b00000},
    {5'd14, 8'h00, 8'h01, 1'b0, 1'b0, 8'h00, 5'b10101, 5'b00101},
    {5'd14, 8'h00, 8'h02, 1'b1, 1'b0, 8'h81, 5'b10101, 5'b10000},
    {5'd15, 8'h00, 8'h81, 1'b0, 1'b0, 8'h03, 5'b10100, 5'b00000},
    {5'd16, 8'h00, 8'h01, 1'b1, 1'b0, 8'h80, 5'b10100, 5'b10000},
    {5'd17, 8'h00, 8'hA5, 1'b1, 1'b1, 8'h5A, 5'b00000, 5'b00000},
    {5'd18, 8'h12, 8'h34, 1'b1, 1'b0, 8'h00, 5'b00100, 5'b00100},
    {5'd19, 8'h12, 8'h34, 1'b1, 1'b1, 8'hFF, 5'b00000, 5'b00000},
    {5'd20, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 5'b00001, 5'b00001},
    {5'd20, 8'h45, 8'h00, 1'b0, 1'b0, 8'h45, 5'b00001, 5'b00000},
    {5'd20, 8'h12, 8'h00, 1'b1, 1'b1, 8'h78, 5'b00001, 5'b00001},
    {5'd31, 8'hEE, 8'h33, 1'b1, 1'b1, 8'h33, 5'b00000, 5'b00000}
  };

  function automatic string tag_of(input logic [4:0] op);
    if (op <= 5'd1)  return "R3";
    if (op <= 5'd4)  return "R4";
    if (op <= 5'd7)  return "R5";
    if (op <= 5'd12) return "R6";
    if (op <= 5'd14) return "R7";
    if (op <= 5'd16) return "R8";
    if (op == 5'd17) return "R9";
    if (op <= 5'd19) return "R10";
    if (op == 5'd20) return "R11";
    return "R12";
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] got,
                     input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "reset res", 16'(res_o), 16'h0);
    chk("R1", "reset we", 16'(flag_we_o), 16'h0);
    chk("R1", "reset nxt", 16'(flag_nxt_o), 16'h0);
    rst = 1'b0;

    // table walk: drive on falling edge, read one falling edge later
    for (int i = 0; i < NV; i++) begin
      op_i = VEC[i][40:36];
      w_i  = VEC[i][35:28];
      f_i  = VEC[i][27:20];
      c_i  = VEC[i][19];
      dc_i = VEC[i][18];
      @(negedge clk);
      chk(tag_of(VEC[i][40:36]), $sformatf("vec %0d res", i), 16'(res_o), 16'(VEC[i][17:10]));
      chk(tag_of(VEC[i][40:36]), $sformatf("vec %0d we", i), 16'(flag_we_o), 16'(VEC[i][9:5]));
      chk(tag_of(VEC[i][40:36]), $sformatf("vec %0d nxt", i), 16'(flag_nxt_o), 16'(VEC[i][4:0]));
    end

    // R2: output must not move before the rising edge
    op_i = 5'd12; f_i = 8'h5C; c_i = 1'b0; dc_i = 1'b0;
    #2;
    chk("R2", "before edge res", 16'(res_o), 16'h0033);
    @(negedge clk);
    chk("R2", "after edge res", 16'(res_o), 16'h005C);
    chk("R2", "after edge nxt", 16'(flag_nxt_o), 16'h0);

    // R11: decimal adjust never clears an incoming carry, low fix via nibble only
    op_i = 5'd20; w_i = 8'h0B; c_i = 1'b1; dc_i = 1'b0;
    @(negedge clk);
    chk("R11", "adjust 0B res", 16'(res_o), 16'h0071);
    chk("R11", "adjust 0B carry", 16'(flag_nxt_o), 16'h0001);

    // R7: rotate right through carry carries bit 0 out
    op_i = 5'd14; f_i = 8'hFF; c_i = 1'b0;
    @(negedge clk);
    chk("R7", "rrc FF res", 16'(res_o), 16'h007F);
    chk("R7", "rrc FF nxt", 16'(flag_nxt_o), 16'h0001);

    // R1: reset over a non-zero output
    op_i = 5'd19;
    @(negedge clk);
    chk("R10", "set before reset", 16'(res_o), 16'h00FF);
    rst = 1'b1;
    op_i = 5'd0; w_i = 8'hFF; f_i = 8'hFF;
    @(negedge clk);
    chk("R1", "mid-run reset res", 16'(res_o), 16'h0);
    chk("R1", "mid-run reset we", 16'(flag_we_o), 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R3", "add after reset", 16'(res_o), 16'h00FE);

    finish_run();
  end
endmodule